// File: doc/BRIEF.md
# Codec Reset and Output-Mute Sequencer

This block turns two asynchronous active-low reset lines into a single system reset for an audio codec. The system is held in reset only while both lines are low. As soon as either line goes high the reset is released. While the system is in reset, the DAC output driver is disabled (high impedance) and every ADC sample word is replaced by zero.

After release, the block waits for a frame-counter start whose timing depends on the clocking mode, using a one-cycle strobe that marks each frame-clock rising edge. In master mode the counter starts on the first strobe. In slave mode the start is deferred until a second full frame period has ended. From the start, the ADC sample word stays masked for a fixed number of frames before samples are passed through. A separate flag reports full operation, which means both reset lines are high.

Top module: `codec_rst_seq`

## Requirements
- R1: `sys_rst` is 1 while both `rst_a_n` and `rst_b_n` are low, and 0 while at least one of them is high, including the case where only one line is high.
- R2: `dac_oe` is 0 (DAC output in high impedance) whenever `sys_rst` is 1, and 1 otherwise.
- R3: `adc_data_o` is all zeros (20 bits by default) while `adc_valid` is 0, and equals `adc_data_i` while `adc_valid` is 1.
- R4: `full_run` is 1 only while both reset lines are high.
- R5: In master mode (`master_mode`=1), `counter_start` pulses in the clock cycle after the first `frame_stb` that follows release.
- R6: In slave mode (`master_mode`=0), `counter_start` pulses in the cycle after the third `frame_stb` that follows release. This is the strobe that ends the second full frame period.
- R7: `adc_valid` rises in the cycle after the 516th `frame_stb` that follows the start strobe, and then stays high while the system is out of reset.
- R8: When the system reset reasserts, `adc_valid` and the started state clear immediately. Strobes received during reset are ignored. The next release begins the sequence from the beginning.
- R9: Each reset line passes through a two-flop synchronizer followed by one output register. A change on a line therefore appears on `sys_rst`, `dac_oe` and `full_run` after exactly three rising clock edges.
- R10: `counter_start` is one cycle wide and fires at most once per release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high block reset |
| rst_a_n | input | 1 | First asynchronous active-low reset line |
| rst_b_n | input | 1 | Second asynchronous active-low reset line |
| master_mode | input | 1 | 1 = master clocking, 0 = slave clocking |
| frame_stb | input | 1 | One-cycle strobe on each frame-clock rising edge |
| adc_data_i | input | ADC_W | Raw ADC sample word |
| sys_rst | output | 1 | Combined system reset, active high |
| counter_start | output | 1 | One-cycle pulse when the frame counter starts |
| adc_valid | output | 1 | ADC samples are trusted and passed through |
| dac_oe | output | 1 | DAC output enable, 0 means high impedance |
| full_run | output | 1 | Both reset lines are high |
| adc_data_o | output | ADC_W | Masked ADC sample word |

## Verification
The bench builds the block with its default parameters: a 516-frame mask window, a two-period slave delay, two synchronizer stages and 20-bit samples. It drives frames only one to four clocks apart, so full 516-frame windows in both modes fit easily in the run, together with an early reassert partway through a mask window. Back-to-back strobes reach the exact start and unmask boundaries. The exact three-edge synchronizer latency is checked one edge early and on the edge itself.

// File: rtl/crs_pkg.sv
package crs_pkg;

    typedef enum logic [1:0] {
        ST_ARMED = 2'd0,
        ST_MASK  = 2'd1,
        ST_OPEN  = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic a;
        logic b;
    } line_pair_t;

    // Number of frame strobes after release at which the counter starts.
    function automatic int unsigned edges_to_start(input logic master,
                                                   input int unsigned slave_periods);
        return master ? 1 : slave_periods + 1;
    endfunction

endpackage

// File: rtl/crs_sync.sv
module crs_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        logic [WIDTH-1:0] r;
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) r <= '0;
                else     r <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) r <= '0;
                else     r <= g_stage[s-1].r;
            end
        end
    end

    assign q = g_stage[STAGES-1].r;

endmodule

// File: rtl/crs_frame_seq.sv
module crs_frame_seq
    import crs_pkg::*;
#(
    parameter int MASK_FRAMES   = 516,
    parameter int SLAVE_PERIODS = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic rel,
    input  logic master_mode,
    input  logic frame_stb,
    output logic counter_start,
    output logic adc_valid
);

    localparam int CNT_W  = $clog2(MASK_FRAMES + 1);
    localparam int EDGE_W = $clog2(SLAVE_PERIODS + 3);

    seq_state_e        state_q;
    logic [EDGE_W-1:0] edge_cnt_q;
    logic [CNT_W-1:0]  frame_cnt_q;
    logic              start_q;
    logic              valid_q;

    logic [EDGE_W-1:0] need;
    logic              hit_start;
    logic              hit_mask;

    always_comb begin
        need      = EDGE_W'(edges_to_start(master_mode, SLAVE_PERIODS));
        hit_start = (state_q == ST_ARMED) && frame_stb &&
                    (EDGE_W'(edge_cnt_q + EDGE_W'(1)) == need);
        hit_mask  = (state_q == ST_MASK) && frame_stb &&
                    (frame_cnt_q == CNT_W'(MASK_FRAMES - 1));
    end

    always_ff @(posedge clk) begin
        if (rst || !rel) begin
            state_q     <= ST_ARMED;
            edge_cnt_q  <= '0;
            frame_cnt_q <= '0;
            start_q     <= 1'b0;
            valid_q     <= 1'b0;
        end else begin
            start_q <= hit_start;
            unique case (state_q)
                ST_ARMED: begin
                    if (hit_start) begin
                        state_q     <= ST_MASK;
                        frame_cnt_q <= '0;
                    end else if (frame_stb) begin
                        edge_cnt_q <= EDGE_W'(edge_cnt_q + EDGE_W'(1));
                    end
                end
                ST_MASK: begin
                    if (hit_mask) begin
                        state_q <= ST_OPEN;
                        valid_q <= 1'b1;
                    end else if (frame_stb) begin
                        frame_cnt_q <= CNT_W'(frame_cnt_q + CNT_W'(1));
                    end
                end
                ST_OPEN: valid_q <= 1'b1;
                default: state_q <= ST_ARMED;
            endcase
        end
    end

    assign counter_start = start_q;
    assign adc_valid     = valid_q;

    // R10
    start_one_shot_chk: assert property (@(posedge clk) disable iff (rst)
        counter_start |=> !counter_start);

    // R7
    unmask_on_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(adc_valid) |-> $past(frame_stb));

    // R5
    start_while_masked_chk: assert property (@(posedge clk) disable iff (rst)
        counter_start |-> !adc_valid);

endmodule

// File: rtl/codec_rst_seq.sv
module codec_rst_seq
    import crs_pkg::*;
#(
    parameter int ADC_W         = 20,
    parameter int MASK_FRAMES   = 516,
    parameter int SLAVE_PERIODS = 2,
    parameter int SYNC_STAGES   = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rst_a_n,
    input  logic             rst_b_n,
    input  logic             master_mode,
    input  logic             frame_stb,
    input  logic [ADC_W-1:0] adc_data_i,
    output logic             sys_rst,
    output logic             counter_start,
    output logic             adc_valid,
    output logic             dac_oe,
    output logic             full_run,
    output logic [ADC_W-1:0] adc_data_o
);

    line_pair_t lines_raw;
    line_pair_t lines_s;
    logic       rel;
    logic       sys_rst_q;
    logic       dac_oe_q;
    logic       full_run_q;

    assign lines_raw = '{a: rst_a_n, b: rst_b_n};

    crs_sync #(
        .WIDTH  ($bits(line_pair_t)),
        .STAGES (SYNC_STAGES)
    ) i_sync (
        .clk (clk),
        .rst (rst),
        .d   (lines_raw),
        .q   (lines_s)
    );

    assign rel = lines_s.a | lines_s.b;

    always_ff @(posedge clk) begin
        if (rst) begin
            sys_rst_q  <= 1'b1;
            dac_oe_q   <= 1'b0;
            full_run_q <= 1'b0;
        end else begin
            sys_rst_q  <= ~rel;
            dac_oe_q   <= rel;
            full_run_q <= lines_s.a & lines_s.b;
        end
    end

    crs_frame_seq #(
        .MASK_FRAMES   (MASK_FRAMES),
        .SLAVE_PERIODS (SLAVE_PERIODS)
    ) i_seq (
        .clk           (clk),
        .rst           (rst),
        .rel           (rel),
        .master_mode   (master_mode),
        .frame_stb     (frame_stb),
        .counter_start (counter_start),
        .adc_valid     (adc_valid)
    );

    assign sys_rst    = sys_rst_q;
    assign dac_oe     = dac_oe_q;
    assign full_run   = full_run_q;
    assign adc_data_o = adc_valid ? adc_data_i : '0;

    // R1
    valid_needs_release_chk: assert property (@(posedge clk) disable iff (rst)
        adc_valid |-> !sys_rst);

    // R4
    full_run_excl_chk: assert property (@(posedge clk) disable iff (rst)
        full_run |-> !sys_rst);

    // R2
    oe_tristate_chk: assert property (@(posedge clk) disable iff (rst)
        sys_rst |-> !dac_oe);

    // R8
    start_out_of_reset_chk: assert property (@(posedge clk) disable iff (rst)
        counter_start |-> !sys_rst);

endmodule

// File: tb/test_codec_rst_seq.sv
`timescale 1ns/1ps
module test_codec_rst_seq;

    localparam int ADC_W = 20;
    localparam int MASK  = 516;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             rst_a_n = 1'b0;
    logic             rst_b_n = 1'b0;
    logic             master_mode = 1'b1;
    logic             frame_stb = 1'b0;
    logic [ADC_W-1:0] adc_data_i = '0;
    logic             sys_rst, counter_start, adc_valid, dac_oe, full_run;
    logic [ADC_W-1:0] adc_data_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    codec_rst_seq i_codec_rst_seq (
        .clk (clk), .rst (rst), .rst_a_n (rst_a_n), .rst_b_n (rst_b_n),
        .master_mode (master_mode), .frame_stb (frame_stb),
        .adc_data_i (adc_data_i), .sys_rst (sys_rst),
        .counter_start (counter_start), .adc_valid (adc_valid),
        .dac_oe (dac_oe), .full_run (full_run), .adc_data_o (adc_data_o)
    );

    function automatic int start_edge(input logic m);
        return m ? 1 : 3;
    endfunction

    function automatic logic exp_valid(input int k, input logic m);
        return k >= start_edge(m) + MASK;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic chk_data(input logic v);
        chk("R3 adc_data_o", 32'(adc_data_o), v ? 32'(adc_data_i) : 32'd0);
    endtask

    task automatic chk_held;
        chk("R1 sys_rst held", 32'(sys_rst), 1);
        chk("R2 dac_oe off", 32'(dac_oe), 0);
        chk("R8 adc_valid cleared", 32'(adc_valid), 0);
        chk("R8 no start in reset", 32'(counter_start), 0);
        chk_data(1'b0);
    endtask

    // Drive a line change, check it is not visible after two edges but is after three.
    task automatic set_lines(input logic a, input logic b);
        logic old_rst;
        old_rst = sys_rst;
        rst_a_n = a;
        rst_b_n = b;
        repeat (2) @(negedge clk);
        chk("R9 latency not early", 32'(sys_rst), 32'(old_rst));
        @(negedge clk);
        chk("R1 sys_rst level", 32'(sys_rst), 32'(!(a | b)));
        chk("R2 dac_oe level", 32'(dac_oe), 32'(a | b));
        chk("R4 full_run level", 32'(full_run), 32'(a & b));
    endtask

    // Send n frame strobes, counting from k0, checking start and mask each cycle.
    task automatic run_frames(input int k0, input int n, input logic m);
        for (int k = k0; k < k0 + n; k++) begin
            int gap;
            gap = ($urandom % 4 == 0) ? 0 : int'($urandom % 4);
            frame_stb = 1'b1;
            @(negedge clk);
            frame_stb = 1'b0;
            adc_data_i = ADC_W'($urandom);
            #1;
            if (m) chk("R5 master start", 32'(counter_start), 32'(k == start_edge(m)));
            else   chk("R6 slave start", 32'(counter_start), 32'(k == start_edge(m)));
            chk("R7 adc_valid", 32'(adc_valid), 32'(exp_valid(k, m)));
            chk_data(exp_valid(k, m));
            for (int g = 0; g < gap; g++) begin
                @(negedge clk);
                adc_data_i = ADC_W'($urandom);
                #1;
                chk("R10 single start", 32'(counter_start), 0);
                chk("R7 adc_valid hold", 32'(adc_valid), 32'(exp_valid(k, m)));
                chk_data(exp_valid(k, m));
            end
        end
    endtask

    initial begin
        void'($urandom(32'h5EED_0714));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk_held();
        chk("R4 full_run reset", 32'(full_run), 0);

        // Master, release through line A only.
        master_mode = 1'b1;
        set_lines(1'b1, 1'b0);
        repeat (2) @(negedge clk);
        run_frames(1, MASK + 6, 1'b1);

        // Reassert, strobes during reset are ignored.
        set_lines(1'b0, 1'b0);
        chk_held();
        frame_stb = 1'b1;
        @(negedge clk);
        frame_stb = 1'b0;
        @(negedge clk);
        chk_held();

        // Slave via line B, abort partway through the mask window.
        master_mode = 1'b0;
        set_lines(1'b0, 1'b1);
        repeat (2) @(negedge clk);
        run_frames(1, 200, 1'b0);
        set_lines(1'b0, 1'b0);
        chk_held();

        // Slave again, full window.
        set_lines(1'b0, 1'b1);
        repeat (2) @(negedge clk);
        run_frames(1, MASK + 8, 1'b0);

        // Both lines high, then drop one: still released.
        set_lines(1'b1, 1'b1);
        chk("R7 valid kept", 32'(adc_valid), 1);
        set_lines(1'b1, 1'b0);
        chk("R7 valid kept one line", 32'(adc_valid), 1);
        set_lines(1'b0, 1'b0);
        chk_held();

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule